// File: doc/BRIEF.md
# Double-Buffered Colour Lookup with Half-Table Interpolation

This block maps every pixel through a per-component colour lookup table on its way to the display output. Each of the three 8-bit components indexes its own 256-entry table of 10-bit values. The three component tables are read in parallel. The result leaves the block a fixed two clocks after the pixel enters, and a valid flag travels with it.

A 32-bit control word selects the behaviour. With the lookup turned off, pixels pass through with each component widened to 10 bits by bit replication. The direct mode indexes the table with the input code. The interpolating mode is meant for 8-bit palette-style frame buffers. It uses only the middle half of the table, entries 64 to 191, and spreads those 128 values over all 256 input codes. Odd codes take the rounded mean of two neighbouring entries.

Table contents are written one entry at a time into a hidden copy while the visible copy keeps serving pixels. A commit pulse seen during vertical blanking exchanges the two copies. The control word is taken only at frame start, so the mode cannot change partway through a frame.

Top module: `clut_interp`

## Requirements
- R1: After reset, `out_valid` and `pix_out` are 0 and the lookup is off (pass-through) until a control word is taken at frame start.
- R2: A pixel presented with `pix_valid` high in cycle t appears on `pix_out` with `out_valid` high after the second rising edge (latency 2). `out_valid` is low when no pixel was presented two cycles earlier.
- R3: With the lookup off, each output component equals the 8-bit input code followed by its own two top bits (`{v, v[7:6]}`).
- R4: Bit 31 of `ctrl_word` turns the lookup on. Bit 30 picks the mode: 1 is direct, 0 is interpolating. All other bits have no effect.
- R5: In direct mode, output component c is bits [10c+9:10c] of the visible table entry addressed by code v. Red is c=0, in the lowest bits of both `pix_in` (8 bits per component) and `wr_data` (10 bits per component).
- R6: In interpolating mode, an even code v yields entry 64 + v/2.
- R7: In interpolating mode, an odd code v below 255 yields (e[64+(v>>1)] + e[65+(v>>1)] + 1) >> 1, using a full-precision sum.
- R8: In interpolating mode, code 255 yields entry 191 unchanged.
- R9: In interpolating mode, entries 0 to 63 and 192 to 255 never affect the output.
- R10: A write with `wr_en` high stores into the hidden table copy. `load_commit` high together with `vblank` high exchanges hidden and visible copies from the next cycle on. `load_commit` without `vblank` has no effect.
- R11: `ctrl_word` is taken only in a cycle with `frame_start` high. Changes at other times have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Control word: bit 31 enable, bit 30 mode |
| frame_start | input | 1 | Frame start pulse; control word sampled here |
| vblank | input | 1 | High during vertical blanking |
| load_commit | input | 1 | Request to exchange hidden and visible tables |
| wr_en | input | 1 | Table entry write strobe |
| wr_addr | input | 8 | Table entry index |
| wr_data | input | 30 | Three 10-bit component values, red lowest |
| pix_valid | input | 1 | Input pixel valid |
| pix_in | input | 24 | Three 8-bit component codes, red lowest |
| out_valid | output | 1 | Output pixel valid |
| pix_out | output | 30 | Three 10-bit mapped components, red lowest |

## Verification
A wrong bank pointer shows up two cycles after the first pixel that follows the bad commit. Every output then carries values from the other table copy. A control register loaded outside frame start shows up the same way: the pixel after the illegal change comes out in the wrong mode. An off-by-one in the interpolation index, or a missing round-up, is visible only for particular codes. The random sweeps are therefore backed by directed codes 0, 1, 127, 128, 254 and 255. A bad valid pipeline is seen on the very next pixel, as a flag one cycle early or late.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int EN_BIT   = 31;
  localparam int MODE_BIT = 30;

  typedef enum logic {
    MODE_INTERP = 1'b0,
    MODE_DIRECT = 1'b1
  } lut_mode_e;

  typedef struct packed {
    logic      en;
    lut_mode_e mode;
  } lut_ctrl_t;
endpackage

// File: rtl/clut_ctrl_sync.sv
module clut_ctrl_sync
  import clut_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              frame_start,
  input  logic              vblank,
  input  logic              load_commit,
  output lut_ctrl_t         ctrl_q,
  output logic              vis_sel,
  output logic              swap_fire,
  output logic              ctrl_load
);
  assign swap_fire = load_commit && vblank;
  assign ctrl_load = frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '{en: 1'b0, mode: MODE_DIRECT};
      vis_sel <= 1'b0;
    end else begin
      if (ctrl_load) begin
        ctrl_q.en   <= ctrl_word[EN_BIT];
        ctrl_q.mode <= lut_mode_e'(ctrl_word[MODE_BIT]);
      end
      if (swap_fire) vis_sel <= ~vis_sel;
    end
  end
endmodule

// File: rtl/clut_index.sv
module clut_index #(
  parameter int IW = 8
) (
  input  logic [IW-1:0] code,
  input  logic          interp,
  output logic [IW-1:0] addr_a,
  output logic [IW-1:0] addr_b
);
  localparam int DEPTH = 1 << IW;
  localparam int QTR   = DEPTH / 4;

  logic [IW-1:0] mid;
  logic          odd_inner;

  assign mid       = IW'(QTR) + (code >> 1);
  assign odd_inner = code[0] && (code != {IW{1'b1}});

  always_comb begin
    if (interp) begin
      addr_a = mid;
      addr_b = odd_inner ? mid + IW'(1) : mid;
    end else begin
      addr_a = code;
      addr_b = code;
    end
  end
endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int IW = 8,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [IW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_sel,
  input  logic [IW-1:0] rd_addr_a,
  input  logic [IW-1:0] rd_addr_b,
  output logic [CW-1:0] rd_a,
  output logic [CW-1:0] rd_b
);
  localparam int DEPTH = 1 << IW;

  logic [CW-1:0] mem [2][DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_sel][wr_addr] <= wr_data;
    rd_a <= mem[rd_sel][rd_addr_a];
    rd_b <= mem[rd_sel][rd_addr_b];
  end
endmodule

// File: rtl/clut_interp.sv
module clut_interp
  import clut_pkg::*;
#(
  parameter int IW     = 8,
  parameter int CW     = 10,
  parameter int NCH    = 3,
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              frame_start,
  input  logic              vblank,
  input  logic              load_commit,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_addr,
  input  logic [NCH*CW-1:0] wr_data,
  input  logic              pix_valid,
  input  logic [NCH*IW-1:0] pix_in,
  output logic              out_valid,
  output logic [NCH*CW-1:0] pix_out
);
  function automatic logic [CW-1:0] widen(input logic [IW-1:0] v);
    logic [CW-1:0] r;
    for (int i = 0; i < CW; i++) r[CW-1-i] = v[IW-1-(i % IW)];
    return r;
  endfunction

  function automatic logic [CW-1:0] blend(input logic [CW-1:0] x, input logic [CW-1:0] y);
    logic [CW:0] s;
    s = {1'b0, x} + {1'b0, y} + (CW+1)'(1);
    return s[CW:1];
  endfunction

  lut_ctrl_t ctrl_q;
  logic      vis_sel, swap_fire, ctrl_load;
  logic      ctrl_en_w, interp_w;

  clut_ctrl_sync #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .frame_start(frame_start),
    .vblank(vblank), .load_commit(load_commit), .ctrl_q(ctrl_q),
    .vis_sel(vis_sel), .swap_fire(swap_fire), .ctrl_load(ctrl_load)
  );

  assign ctrl_en_w = ctrl_q.en;
  assign interp_w  = (ctrl_q.mode == MODE_INTERP);

  logic              valid_s1, en_s1;
  logic [NCH*IW-1:0] pix_s1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_s1  <= 1'b0;
      en_s1     <= 1'b0;
      pix_s1    <= '0;
      out_valid <= 1'b0;
    end else begin
      valid_s1  <= pix_valid;
      en_s1     <= ctrl_en_w;
      pix_s1    <= pix_in;
      out_valid <= valid_s1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [IW-1:0] code, ia, ib;
    logic [CW-1:0] ra, rb, q;

    assign code = pix_in[c*IW +: IW];

    clut_index #(.IW(IW)) u_idx (
      .code(code), .interp(interp_w), .addr_a(ia), .addr_b(ib)
    );

    clut_bank #(.IW(IW), .CW(CW)) u_bank (
      .clk(clk), .wr_en(wr_en), .wr_sel(~vis_sel), .wr_addr(wr_addr),
      .wr_data(wr_data[c*CW +: CW]), .rd_sel(vis_sel),
      .rd_addr_a(ia), .rd_addr_b(ib), .rd_a(ra), .rd_b(rb)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= en_s1 ? blend(ra, rb) : widen(pix_s1[c*IW +: IW]);
    end

    assign pix_out[c*CW +: CW] = q;
  end
endmodule

// File: rtl/clut_interp_chk.sv
module clut_interp_chk #(
  parameter int IW     = 8,
  parameter int CW     = 10,
  parameter int NCH    = 3,
  parameter int CTRL_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              frame_start,
  input logic              vblank,
  input logic              load_commit,
  input logic              pix_valid,
  input logic [NCH*IW-1:0] pix_in,
  input logic              out_valid,
  input logic [NCH*CW-1:0] pix_out,
  input logic              ctrl_en,
  input logic              interp,
  input logic              vis_sel
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  function automatic logic [NCH*CW-1:0] widen_all(input logic [NCH*IW-1:0] p);
    logic [NCH*CW-1:0] r;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < CW; i++)
        r[c*CW + CW-1-i] = p[c*IW + IW-1-(i % IW)];
    return r;
  endfunction

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (out_valid == $past(pix_valid, 2)));

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && out_valid && !$past(ctrl_en, 2))
      |-> (pix_out == widen_all($past(pix_in, 2))));

  assert_ctrl_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (ctrl_en == $past(ctrl_word[31]) && interp == !$past(ctrl_word[30])));

  assert_commit_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_commit && !vblank) |=> $stable(vis_sel));

  assert_commit_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_commit && vblank) |=> (vis_sel != $past(vis_sel)));

  assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(ctrl_en) && $stable(interp)));
endmodule

bind clut_interp clut_interp_chk #(.IW(IW), .CW(CW), .NCH(NCH), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .frame_start(frame_start),
  .vblank(vblank), .load_commit(load_commit), .pix_valid(pix_valid), .pix_in(pix_in),
  .out_valid(out_valid), .pix_out(pix_out), .ctrl_en(ctrl_en_w), .interp(interp_w),
  .vis_sel(vis_sel)
);

// File: tb/clut_interp_test.sv
module clut_interp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic        frame_start = 1'b0, vblank = 1'b0, load_commit = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [29:0] wr_data = '0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_in = '0;
  logic        out_valid;
  logic [29:0] pix_out;

  int errors = 0, checks = 0;

  logic [29:0] tbl [2][256];
  int          m_vis = 0;
  bit          m_en = 0, m_direct = 1;
  logic [29:0] saved [256];

  always #2 clk = ~clk;

  clut_interp uut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .frame_start(frame_start),
    .vblank(vblank), .load_commit(load_commit), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pix_valid(pix_valid), .pix_in(pix_in),
    .out_valid(out_valid), .pix_out(pix_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ent(int idx, int c);
    return int'((tbl[m_vis][idx] >> (10*c)) & 30'h3ff);
  endfunction

  function automatic int exp_comp(int v, int c);
    int k;
    if (!m_en) return v * 4 + v / 64;
    if (m_direct) return ent(v, c);
    if (v == 255) return ent(191, c);
    k = 64 + v / 2;
    if (v % 2 == 0) return ent(k, c);
    return (ent(k, c) + ent(k + 1, c) + 1) / 2;
  endfunction

  function automatic logic [29:0] exp_pix(logic [23:0] p);
    logic [29:0] r;
    for (int c = 0; c < 3; c++) r[10*c +: 10] = 10'(exp_comp(int'(p[8*c +: 8]), c));
    return r;
  endfunction

  task automatic put_entry(input int a, input logic [29:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    tbl[1 - m_vis][a] = d;
  endtask

  task automatic commit(input bit vb);
    @(negedge clk);
    load_commit = 1'b1; vblank = vb;
    @(negedge clk);
    load_commit = 1'b0; vblank = 1'b0;
    if (vb) m_vis = 1 - m_vis;
  endtask

  task automatic new_frame(input logic [31:0] w);
    @(negedge clk);
    frame_start = 1'b1; ctrl_word = w;
    @(negedge clk);
    frame_start = 1'b0;
    m_en = w[31]; m_direct = w[30];
  endtask

  task automatic send(input logic [23:0] p, input string req, output logic [29:0] got);
    @(negedge clk);
    pix_valid = 1'b1; pix_in = p;
    @(negedge clk);
    pix_valid = 1'b0;
    check("R2 early valid", 32'(out_valid), 32'd0);
    @(negedge clk);
    check("R2 valid", 32'(out_valid), 32'd1);
    check(req, 32'(pix_out), 32'(exp_pix(p)));
    got = pix_out;
  endtask

  task automatic fill_random();
    for (int a = 0; a < 256; a++) put_entry(a, 30'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [29:0] got;
    void'($urandom(32'h5eed_c1a7));
    repeat (4) @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 pix_out", 32'(pix_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", 32'(out_valid), 32'd0);

    // R1 / R3: pass-through before any frame start
    send(24'hff_80_3f, "R1 R3 bypass", got);
    for (int i = 0; i < 20; i++) send(24'($urandom), "R3 bypass random", got);

    // R10: load table A, commit in blanking
    fill_random();
    commit(1'b1);
    new_frame(32'hC000_0000);
    for (int i = 0; i < 30; i++) send(24'($urandom), "R5 direct random", got);
    send(24'h00_ff_00, "R5 direct corners", got);

    // R10: load table B, commit outside blanking is ignored
    fill_random();
    commit(1'b0);
    for (int i = 0; i < 20; i++) send(24'($urandom), "R10 commit outside vblank ignored", got);
    commit(1'b1);
    for (int i = 0; i < 20; i++) send(24'($urandom), "R10 swap in vblank", got);

    // R11: control change without frame start has no effect
    @(negedge clk);
    ctrl_word = 32'h0000_0000;
    for (int i = 0; i < 10; i++) send(24'($urandom), "R11 ctrl held", got);
    new_frame(32'h0000_0000);
    send(24'h12_34_56, "R11 R3 disabled at frame start", got);

    // R4: interpolating mode with noise in other bits
    new_frame(32'h8000_0000 | ($urandom & 32'h3fff_ffff));
    for (int i = 0; i < 200; i++) send(24'($urandom), "R4 R6 R7 interp random", got);
    send(24'h00_00_00, "R6 code 0", got);
    send(24'h01_01_01, "R7 code 1", got);
    send(24'h80_7f_80, "R6 R7 codes 127 128", got);
    send(24'hfe_fe_fe, "R6 code 254", got);
    send(24'hff_ff_ff, "R8 code 255", got);
    send(24'hfd_ff_fe, "R7 R8 top codes", got);

    // R9: hidden copy with same middle, different outer entries
    for (int a = 0; a < 256; a++) begin
      logic [29:0] d;
      d = (a >= 64 && a <= 191) ? tbl[m_vis][a] : 30'($urandom);
      put_entry(a, d);
    end
    for (int v = 0; v < 256; v++) begin
      send({8'(v), 8'(255 - v), 8'(v)}, "R9 sweep before", got);
      saved[v] = got;
    end
    commit(1'b1);
    for (int v = 0; v < 256; v++) begin
      send({8'(v), 8'(255 - v), 8'(v)}, "R9 sweep after", got);
      check("R9 outer entries unused", 32'(got), 32'(saved[v]));
    end

    // R5: direct mode again, mixed noise bits
    new_frame(32'hC000_0000 | ($urandom & 32'h3fff_ffff));
    for (int i = 0; i < 100; i++) send(24'($urandom), "R5 direct random 2", got);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule